// File: doc/BRIEF.md
# Strided 2D DMA Address Generator

The generator takes one transfer request at a time and turns it into a stream of burst commands for a memory bus. A request describes a two-dimensional region: a number of rows, each a fixed number of bytes long, with a fixed byte distance (the stride) from the start of one row to the start of the next. Row length and row count arrive encoded as the value minus one. Each row is cut into bus-width beats, and these are grouped into bursts of bounded size that never straddle a 4 KB page.

A request is checked for legality when it is accepted. A request that breaks the alignment or size rules produces an error pulse and no bus traffic. A legal request runs until its last burst is taken, and then produces a done pulse that carries the request's tag. In cyclic mode the walk starts again at the start address after every full pass, signalling done each time, until the enable input is dropped. The address of the burst being offered is always visible on a status output.

Top module: `dma2d_addr_gen`

## Requirements
- R1: A row holds `req_xlen_m1`+1 bytes and a request covers `req_ylen_m1`+1 rows.
- R2: Row r (counted from 0) begins at `req_start` + r × `req_stride`. Inside a row the bursts are contiguous and ascending, and the rows are walked in increasing r.
- R3: When `req_ylen_m1` is 0 the stride is ignored: it is neither checked nor used, and any value gives the same commands.
- R4: A beat is 2^`req_wsel` bytes. `cmd_beats` gives the burst length as a plain beat count from 1 to 16. Each burst is the largest that fits the rest of the row, the 16-beat limit and the page limit.
- R5: No burst crosses a 4096-byte address boundary.
- R6: `done_valid` is high for exactly one cycle, in the cycle after the handshake of the last burst of the last row. During that cycle `done_id` carries the request's `req_id`.
- R7: If `req_cyclic` is set, the handshake of the final burst of a pass is followed by a new pass from `req_start`, with a done pulse for each pass. Dropping `enable` returns the block to idle on the next edge, with no further command and no done pulse.
- R8: A request is rejected if `req_start` or the row length is not a multiple of the beat size, or if it has more than one row and the stride is not such a multiple. Rejection gives `err_valid` high for one cycle after acceptance and issues no command.
- R9: A request is also rejected in three further cases: it has more than one row and a stride smaller than the row length; its row length is 2^16 bytes, which exceeds the 16-bit length limit; or `req_wsel` exceeds 4.
- R10: While `cmd_valid` is high, `cur_addr` equals `cmd_addr`.
- R11: While `cmd_ready` is low, an offered command keeps its address and beat count.
- R12: `req_ready` is high exactly when the block is idle and `enable` is high. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable; low stops a running walk |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_start | input | 32 | Start byte address |
| req_xlen_m1 | input | 16 | Row length in bytes minus one |
| req_ylen_m1 | input | 16 | Row count minus one |
| req_stride | input | 16 | Byte distance between row starts |
| req_cyclic | input | 1 | Restart after each pass |
| req_wsel | input | 3 | Log2 of beat size in bytes |
| req_id | input | 4 | Request tag |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Burst command taken |
| cmd_addr | output | 32 | Burst start address |
| cmd_beats | output | 5 | Burst beat count (1 to 16) |
| cur_addr | output | 32 | Address currently being issued (status) |
| done_valid | output | 1 | Pass complete pulse |
| done_id | output | 4 | Tag of the completed request |
| err_valid | output | 1 | Request rejected pulse |

## Verification
The assertions check on every cycle the properties that apply to each burst: beat count in range, beat alignment, no page crossing and stability under backpressure. They also check that error pulses never coincide with commands, and that done pulses follow only an active walk. Whether the burst sequence covers exactly the requested rows at the right stride, whether the done pulse and its tag come at the end of a pass, and whether cyclic restart and disable stop where they should can only be shown by the bench's scenarios. The bench compares every handshake against a model of the region walk. The same holds for the rejection of each illegal request type.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   typedef enum logic {
      G_IDLE = 1'b0,
      G_RUN  = 1'b1
   } gen_state_e;
endpackage

// File: rtl/dma2d_req_check.sv
module dma2d_req_check #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int ROWS_W     = 16,
   parameter int WSEL_W     = 3,
   parameter int MAX_W_LOG2 = 4
) (
   input  logic [ADDR_W-1:0] start,
   input  logic [LEN_W-1:0]  xlen_m1,
   input  logic [ROWS_W-1:0] ylen_m1,
   input  logic [LEN_W-1:0]  stride,
   input  logic [WSEL_W-1:0] wsel,
   output logic              bad
);
   localparam int PAD_LEN  = ADDR_W - LEN_W - 1;
   localparam int PAD_STR  = ADDR_W - LEN_W;

   logic [ADDR_W-1:0] mask;
   logic [LEN_W:0]    row_bytes;
   logic              multi_row;
   logic              width_bad, start_bad, len_bad, stride_bad, short_bad, long_bad;

   always_comb begin
      mask       = (ADDR_W'(1) << wsel) - ADDR_W'(1);
      row_bytes  = {1'b0, xlen_m1} + {{LEN_W{1'b0}}, 1'b1};
      multi_row  = |ylen_m1;
      width_bad  = wsel > WSEL_W'(MAX_W_LOG2);
      start_bad  = |(start & mask);
      len_bad    = |({{PAD_LEN{1'b0}}, row_bytes} & mask);
      stride_bad = multi_row && (|({{PAD_STR{1'b0}}, stride} & mask));
      short_bad  = multi_row && ({1'b0, stride} < row_bytes);
      long_bad   = &xlen_m1;
      bad        = width_bad | start_bad | len_bad | stride_bad | short_bad | long_bad;
   end
endmodule

// File: rtl/dma2d_burst_calc.sv
module dma2d_burst_calc #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int WSEL_W    = 3,
   parameter int MAX_BURST = 16,
   parameter int BND_LOG2  = 12,
   parameter bit SPLIT     = 1'b1,
   localparam int BEAT_W   = $clog2(MAX_BURST + 1)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W:0]    rem_bytes,
   input  logic [WSEL_W-1:0] wsel,
   output logic [BEAT_W-1:0] beats
);
   localparam int CW = (LEN_W > BND_LOG2) ? LEN_W + 1 : BND_LOG2 + 1;

   logic [CW-1:0] rem_beats;
   logic [CW-1:0] bnd_beats;
   logic [CW-1:0] pick;

   assign rem_beats = CW'(rem_bytes >> wsel);

   generate
      if (SPLIT) begin : g_page
         logic [BND_LOG2:0] to_edge;
         assign to_edge   = (BND_LOG2+1)'(1 << BND_LOG2) - {1'b0, addr[BND_LOG2-1:0]};
         assign bnd_beats = CW'(to_edge >> wsel);
      end else begin : g_nopage
         assign bnd_beats = {CW{1'b1}};
      end
   endgenerate

   always_comb begin
      pick = CW'(MAX_BURST);
      if (rem_beats < pick) pick = rem_beats;
      if (bnd_beats < pick) pick = bnd_beats;
      beats = BEAT_W'(pick);
   end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker
   import dma2d_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int ROWS_W     = 16,
   parameter int WSEL_W     = 3,
   parameter int ID_W       = 4,
   parameter int MAX_BURST  = 16,
   parameter int BND_LOG2   = 12,
   parameter bit SPLIT      = 1'b1,
   localparam int BEAT_W    = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              req_valid,
   input  logic              req_bad,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [LEN_W-1:0]  req_xlen_m1,
   input  logic [ROWS_W-1:0] req_ylen_m1,
   input  logic [LEN_W-1:0]  req_stride,
   input  logic              req_cyclic,
   input  logic [WSEL_W-1:0] req_wsel,
   input  logic [ID_W-1:0]   req_id,
   input  logic [BEAT_W-1:0] beats,
   output logic [LEN_W:0]    rem_bytes,
   output logic [WSEL_W-1:0] cfg_wsel,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              done_valid,
   output logic [ID_W-1:0]   done_id,
   output logic              err_valid
);
   localparam int STEP_PAD = LEN_W + 1 - BEAT_W;
   localparam int APAD     = ADDR_W - LEN_W - 1;

   gen_state_e        state;
   logic [ADDR_W-1:0] cfg_start, row_start;
   logic [LEN_W:0]    cfg_row;
   logic [ROWS_W-1:0] cfg_rows_m1, rows_left;
   logic [LEN_W-1:0]  cfg_stride;
   logic              cfg_cyc;
   logic [ID_W-1:0]   cfg_id;
   logic [LEN_W:0]    step;
   logic [ADDR_W-1:0] next_row;
   logic              row_end, pass_end;

   assign req_ready = (state == G_IDLE) && enable;
   assign cmd_valid = (state == G_RUN);

   always_comb begin
      step     = {{STEP_PAD{1'b0}}, beats} << cfg_wsel;
      next_row = row_start + {{(ADDR_W-LEN_W){1'b0}}, cfg_stride};
      row_end  = (rem_bytes == step);
      pass_end = row_end && (rows_left == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= G_IDLE;
         cfg_start   <= '0;
         row_start   <= '0;
         cur_addr    <= '0;
         cfg_row     <= '0;
         rem_bytes   <= '0;
         cfg_rows_m1 <= '0;
         rows_left   <= '0;
         cfg_stride  <= '0;
         cfg_cyc     <= 1'b0;
         cfg_wsel    <= '0;
         cfg_id      <= '0;
         done_valid  <= 1'b0;
         done_id     <= '0;
         err_valid   <= 1'b0;
      end else begin
         done_valid <= 1'b0;
         err_valid  <= 1'b0;
         case (state)
            G_IDLE: begin
               if (req_valid && enable) begin
                  if (req_bad) begin
                     err_valid <= 1'b1;
                  end else begin
                     state       <= G_RUN;
                     cfg_start   <= req_start;
                     row_start   <= req_start;
                     cur_addr    <= req_start;
                     cfg_row     <= {1'b0, req_xlen_m1} + {{LEN_W{1'b0}}, 1'b1};
                     rem_bytes   <= {1'b0, req_xlen_m1} + {{LEN_W{1'b0}}, 1'b1};
                     cfg_rows_m1 <= req_ylen_m1;
                     rows_left   <= req_ylen_m1;
                     cfg_stride  <= req_stride;
                     cfg_cyc     <= req_cyclic;
                     cfg_wsel    <= req_wsel;
                     cfg_id      <= req_id;
                  end
               end
            end
            default: begin
               if (!enable) begin
                  state <= G_IDLE;
               end else if (cmd_ready) begin
                  if (pass_end) begin
                     done_valid <= 1'b1;
                     done_id    <= cfg_id;
                     if (cfg_cyc) begin
                        row_start <= cfg_start;
                        cur_addr  <= cfg_start;
                        rem_bytes <= cfg_row;
                        rows_left <= cfg_rows_m1;
                     end else begin
                        state <= G_IDLE;
                     end
                  end else if (row_end) begin
                     row_start <= next_row;
                     cur_addr  <= next_row;
                     rem_bytes <= cfg_row;
                     rows_left <= rows_left - ROWS_W'(1);
                  end else begin
                     cur_addr  <= cur_addr + {{APAD{1'b0}}, step};
                     rem_bytes <= rem_bytes - step;
                  end
               end
            end
         endcase
      end
   end

   // R11: an offered burst is held while the bus stalls
   a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && enable && !cmd_ready |=> cmd_valid && $stable(cur_addr) && $stable(beats));

   // R4: burst length within 1..MAX_BURST
   a_r4_beats_range: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (beats != '0) && (beats <= BEAT_W'(MAX_BURST)));

   // R8: every issued address sits on a beat boundary
   a_r8_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ((cur_addr & ((ADDR_W'(1) << cfg_wsel) - ADDR_W'(1))) == '0));

   // R8: a rejection never overlaps bus traffic
   a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> !cmd_valid && !done_valid);

   // R6: completion only follows an active walk
   a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(state == G_RUN));

   // R12: requests are taken only while idle
   a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cmd_valid && enable);

   generate
      if (SPLIT) begin : g_chk_page
         // R5: burst stays inside one page
         a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_valid |-> (({1'b0, cur_addr[BND_LOG2-1:0]} + (BND_LOG2+1)'(step))
                           <= (BND_LOG2+1)'(1 << BND_LOG2)));
      end
   endgenerate
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int ROWS_W     = 16,
   parameter int ID_W       = 4,
   parameter int MAX_W_LOG2 = 4,
   parameter int MAX_BURST  = 16,
   parameter int BND_LOG2   = 12,
   parameter bit SPLIT      = 1'b1,
   localparam int WSEL_W    = $clog2(MAX_W_LOG2 + 1),
   localparam int BEAT_W    = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [LEN_W-1:0]  req_xlen_m1,
   input  logic [ROWS_W-1:0] req_ylen_m1,
   input  logic [LEN_W-1:0]  req_stride,
   input  logic              req_cyclic,
   input  logic [WSEL_W-1:0] req_wsel,
   input  logic [ID_W-1:0]   req_id,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [BEAT_W-1:0] cmd_beats,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              done_valid,
   output logic [ID_W-1:0]   done_id,
   output logic              err_valid
);
   generate
      if (LEN_W + 1 >= ADDR_W) begin : g_bad_len
         $error("LEN_W must be smaller than ADDR_W - 1");
      end
      if (MAX_W_LOG2 >= BND_LOG2) begin : g_bad_bnd
         $error("beat size must be smaller than the page");
      end
      if (MAX_BURST < 1 || LEN_W + 1 <= BEAT_W) begin : g_bad_burst
         $error("MAX_BURST out of range");
      end
   endgenerate

   logic              bad;
   logic [LEN_W:0]    rem_bytes;
   logic [WSEL_W-1:0] cfg_wsel;
   logic [BEAT_W-1:0] beats;

   dma2d_req_check #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROWS_W(ROWS_W),
      .WSEL_W(WSEL_W), .MAX_W_LOG2(MAX_W_LOG2)
   ) u_check (
      .start(req_start), .xlen_m1(req_xlen_m1), .ylen_m1(req_ylen_m1),
      .stride(req_stride), .wsel(req_wsel), .bad(bad)
   );

   dma2d_burst_calc #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WSEL_W(WSEL_W),
      .MAX_BURST(MAX_BURST), .BND_LOG2(BND_LOG2), .SPLIT(SPLIT)
   ) u_calc (
      .addr(cur_addr), .rem_bytes(rem_bytes), .wsel(cfg_wsel), .beats(beats)
   );

   dma2d_walker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROWS_W(ROWS_W), .WSEL_W(WSEL_W),
      .ID_W(ID_W), .MAX_BURST(MAX_BURST), .BND_LOG2(BND_LOG2), .SPLIT(SPLIT)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .req_valid(req_valid), .req_bad(bad), .req_ready(req_ready),
      .req_start(req_start), .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
      .req_stride(req_stride), .req_cyclic(req_cyclic), .req_wsel(req_wsel),
      .req_id(req_id), .beats(beats), .rem_bytes(rem_bytes), .cfg_wsel(cfg_wsel),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cur_addr(cur_addr),
      .done_valid(done_valid), .done_id(done_id), .err_valid(err_valid)
   );

   assign cmd_addr  = cur_addr;
   assign cmd_beats = beats;
endmodule

// File: tb/dma2d_addr_gen_bench.sv
module dma2d_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_start = '0;
   logic [15:0] req_xlen_m1 = '0;
   logic [15:0] req_ylen_m1 = '0;
   logic [15:0] req_stride = '0;
   logic        req_cyclic = 1'b0;
   logic [2:0]  req_wsel = '0;
   logic [3:0]  req_id = '0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [31:0] cmd_addr;
   logic [4:0]  cmd_beats;
   logic [31:0] cur_addr;
   logic        done_valid;
   logic [3:0]  done_id;
   logic        err_valid;

   int checks = 0;
   int failures = 0;
   int cyc_cnt = 0;

   always #5 clk = ~clk;

   dma2d_addr_gen u_dma2d_addr_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_start(req_start), .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1),
      .req_stride(req_stride), .req_cyclic(req_cyclic), .req_wsel(req_wsel),
      .req_id(req_id), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .cur_addr(cur_addr),
      .done_valid(done_valid), .done_id(done_id), .err_valid(err_valid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic put_req(input [31:0] st, input [15:0] xm1, input [15:0] ym1,
                          input [15:0] strd, input [2:0] w, input cyc, input [3:0] id);
      @(negedge clk);
      req_start = st; req_xlen_m1 = xm1; req_ylen_m1 = ym1; req_stride = strd;
      req_wsel = w; req_cyclic = cyc; req_id = id; req_valid = 1'b1;
      check(req_ready == 1'b1, "R12", "ready while idle", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Walk one request, comparing each handshake to a model of the region.
   task automatic run_xfer(input [31:0] st, input [15:0] xm1, input [15:0] ym1,
                           input [15:0] strd, input [2:0] w, input cyc,
                           input [3:0] id, input int passes, input bit bp,
                           input string tag);
      longint m_cur, m_row, m_rem, m_left, e_beats, to_pg, step;
      bit exp_done = 1'b0;
      int seen = 0;
      bit bursts_ok = 1'b1;
      put_req(st, xm1, ym1, strd, w, cyc, id);
      m_cur = st; m_row = st; m_rem = longint'(xm1) + 1; m_left = ym1;
      for (int i = 0; i < 20000; i++) begin
         if (exp_done) begin
            check(done_valid == 1'b1 && done_id == id, "R6", {tag, " done pulse/id"},
                  {done_valid, done_id}, {1'b1, id});
            seen++;
            exp_done = 1'b0;
         end else if (done_valid) begin
            check(1'b0, "R6", {tag, " spurious done"}, 1, 0);
         end
         if (seen == passes) break;
         cmd_ready = bp ? 1'($urandom % 2) : 1'b1;
         if (cmd_valid) begin
            to_pg = 4096 - (m_cur % 4096);
            e_beats = 16;
            if ((m_rem >> w) < e_beats) e_beats = m_rem >> w;
            if ((to_pg >> w) < e_beats) e_beats = to_pg >> w;
            if (cmd_addr != m_cur[31:0] || longint'(cmd_beats) != e_beats) begin
               bursts_ok = 1'b0;
               check(1'b0, "R2/R4/R5", {tag, " burst addr"}, cmd_addr, m_cur);
               check(1'b0, "R4", {tag, " burst beats"}, cmd_beats, e_beats);
            end
            if (cur_addr != cmd_addr) check(1'b0, "R10", {tag, " status addr"}, cur_addr, cmd_addr);
            if (cmd_ready) begin
               step = e_beats << w;
               if (step == m_rem) begin
                  if (m_left == 0) begin
                     exp_done = 1'b1;
                     if (cyc) begin
                        m_cur = st; m_row = st; m_rem = longint'(xm1) + 1; m_left = ym1;
                     end
                  end else begin
                     m_row = m_row + strd; m_cur = m_row;
                     m_rem = longint'(xm1) + 1; m_left = m_left - 1;
                  end
               end else begin
                  m_cur = m_cur + step; m_rem = m_rem - step;
               end
            end
         end
         @(negedge clk);
      end
      check(seen == passes, "R1", {tag, " pass count"}, seen, passes);
      check(bursts_ok, "R2", {tag, " burst sequence"}, bursts_ok, 1);
      if (cyc) begin
         enable = 1'b0; cmd_ready = 1'b0;
         @(negedge clk);
         check(cmd_valid == 1'b0, "R7", "disable stops walk", cmd_valid, 0);
         check(req_ready == 1'b0, "R12", "no ready while disabled", req_ready, 0);
         cmd_ready = 1'b1;
         repeat (3) begin
            @(negedge clk);
            check(cmd_valid == 1'b0 && done_valid == 1'b0, "R7", "quiet after disable",
                  {cmd_valid, done_valid}, 0);
         end
         enable = 1'b1;
         @(negedge clk);
         check(req_ready == 1'b1, "R12", "ready after re-enable", req_ready, 1);
      end else begin
         check(cmd_valid == 1'b0 && req_ready == 1'b1, "R6", {tag, " idle after done"},
               {cmd_valid, req_ready}, 2'b01);
      end
      cmd_ready = 1'b0;
   endtask

   task automatic expect_reject(input [31:0] st, input [15:0] xm1, input [15:0] ym1,
                                input [15:0] strd, input [2:0] w, input string req,
                                input string tag);
      put_req(st, xm1, ym1, strd, w, 1'b0, 4'hE);
      cmd_ready = 1'b1;
      check(err_valid == 1'b1 && cmd_valid == 1'b0, req, {tag, " rejected"},
            {err_valid, cmd_valid}, 2'b10);
      @(negedge clk);
      check(err_valid == 1'b0 && cmd_valid == 1'b0 && req_ready == 1'b1, req,
            {tag, " no traffic"}, {err_valid, cmd_valid, req_ready}, 3'b001);
      cmd_ready = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(cmd_valid == 1'b0, "R12", "reset cmd_valid", cmd_valid, 0);
      check(done_valid == 1'b0 && err_valid == 1'b0, "R6", "reset pulses",
            {done_valid, err_valid}, 0);
      check(cur_addr == 32'h0, "R10", "reset status addr", cur_addr, 0);
      check(req_ready == 1'b1, "R12", "reset ready", req_ready, 1);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc_cnt++;
         if (cyc_cnt > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; enable = 1'b1;
      t_reset();
      // R1 R4: 64-byte row, 4-byte beats, one 16-beat burst
      run_xfer(32'h100, 16'd63, 16'd0, 16'd0, 3'd2, 1'b0, 4'h3, 1, 1'b0, "R1 1D");
      // R3: single row with an odd stride is accepted and stride is unused
      run_xfer(32'h200, 16'd31, 16'd0, 16'd3, 3'd2, 1'b0, 4'h5, 1, 1'b0, "R3 stride ignored");
      // R2 R11: three rows at stride 0x100, 8-byte beats, with backpressure
      run_xfer(32'h1000, 16'd31, 16'd2, 16'h100, 3'd3, 1'b0, 4'h6, 1, 1'b1, "R2 2D");
      // R5: rows starting 16 bytes below a page edge are split there
      run_xfer(32'h0FF0, 16'd63, 16'd1, 16'h2000, 3'd2, 1'b0, 4'h7, 1, 1'b0, "R5 page");
      // R4: 256-byte row gives four 16-beat bursts
      run_xfer(32'h4000, 16'd255, 16'd0, 16'd0, 3'd2, 1'b0, 4'h8, 1, 1'b1, "R4 long row");
      // R4: byte-wide beats from an odd address
      run_xfer(32'h2003, 16'd4, 16'd0, 16'd0, 3'd0, 1'b0, 4'h1, 1, 1'b0, "R4 byte beats");
      // R7: cyclic, three passes, then disable
      run_xfer(32'h3000, 16'd15, 16'd1, 16'h40, 3'd2, 1'b1, 4'h9, 3, 1'b1, "R7 cyclic");
      // R8 R9: illegal requests
      expect_reject(32'h102, 16'd15, 16'd0, 16'd0, 3'd2, "R8", "misaligned start");
      expect_reject(32'h100, 16'd5, 16'd0, 16'd0, 3'd2, "R8", "misaligned length");
      expect_reject(32'h100, 16'd15, 16'd1, 16'h42, 3'd2, "R8", "misaligned stride");
      expect_reject(32'h100, 16'd15, 16'd1, 16'd8, 3'd2, "R9", "stride shorter than row");
      expect_reject(32'h100, 16'hFFFF, 16'd0, 16'd0, 3'd0, "R9", "row too long");
      expect_reject(32'h100, 16'd31, 16'd0, 16'd0, 3'd5, "R9", "beat width too wide");
      // R1: after rejections, a legal two-row request still runs
      run_xfer(32'h8000, 16'd7, 16'd1, 16'd8, 3'd2, 1'b0, 4'hA, 1, 1'b0, "R1 tight stride");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule